// File: doc/BRIEF.md
# Sparse Hit-Channel Token Sequencer

This block walks a readout token over a two-dimensional array of channel hit flags (16 rows by 16 columns by default). When a token arrives from upstream, the block takes a snapshot of the hit mask. On each readout step it then moves the token to the next channel whose flag is set, and drives that channel's index to an external analog output multiplexer. Channels whose flags are clear are passed over within the same step, so the number of steps equals the number of set flags plus one.

The mask can be the raw trigger pattern, which gives sparse readout. It can also be a pattern edited by the user, for example to add neighbours of a hit pixel so that shared charge is also read. Once every flagged channel has been presented, the block emits a one-cycle token pulse to the next device in a daisy chain and goes idle. All chained devices therefore share one set of readout lines.

Top module: `tok_scan_seq`

## Requirements
- R1: After reset, `chan_idx_o` is 0 and `chan_vld_o`, `busy_o` and `token_o` are all low.
- R2: When `token_i` is high on a clock edge while idle and the mask has at least one set bit, the mask is captured and `busy_o` is high after that edge. `chan_vld_o` stays low until the first step.
- R3: Each clock edge with `step_i` high during a scan presents the next set channel, with `chan_vld_o` high. Channels are taken in ascending index order, where index = row × COLS + column and bit k of `hit_mask_i` is channel k. Exactly one channel is presented per step.
- R4: A channel whose captured bit is clear is never presented.
- R5: During a scan, edges with `step_i` low leave `chan_idx_o`, `chan_vld_o` and `busy_o` unchanged.
- R6: The first step after the last set channel has been presented raises `token_o` for exactly one cycle. On that same edge `chan_vld_o` and `busy_o` fall.
- R7: A token that arrives while idle with an all-zero mask raises `token_o` for one cycle after that edge. In this case `busy_o` and `chan_vld_o` stay low.
- R8: Changes to `hit_mask_i` during a scan have no effect on which channels are presented.
- R9: `token_i` is ignored while a scan is in progress, and the scan does not restart.
- R10: While idle with `token_i` low, `step_i` has no effect. `busy_o`, `chan_vld_o` and `token_o` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hit_mask_i | input | 256 | Channel hit flags, bit k = channel k |
| token_i | input | 1 | Token from the upstream device |
| step_i | input | 1 | Readout step enable |
| chan_idx_o | output | 8 | Index of the channel holding the token |
| chan_vld_o | output | 1 | A channel holds the token |
| busy_o | output | 1 | Scan in progress |
| token_o | output | 1 | One-cycle token pulse to the downstream device |

## Verification
The bench covers the following corner cases:
- Flags on channel 0, channel 255 and across row boundaries. An encoder that is off by one, or that favours the wrong end, would present out of order or skip an edge channel.
- Idle cycles placed between steps. A design that advanced on every clock would run ahead of the model.
- Mask edits and new tokens during a scan. A design that did not hold its snapshot would present the wrong channels or restart the scan.
- An all-zero mask. A wrong design would either hang busy or present a spurious channel instead of passing the token on at once.

// File: rtl/tss_pkg.sv
package tss_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } tss_state_e;
endpackage

// File: rtl/tss_row_enc.sv
// Lowest-set-bit finder for one row.
module tss_row_enc #(
  parameter int W   = 16,
  localparam int PW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec_i,
  output logic          any_o,
  output logic [PW-1:0] pos_o
);
  always_comb begin
    pos_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) pos_o = PW'(i);
    end
  end
  assign any_o = |vec_i;
endmodule

// File: rtl/tss_prio_enc.sv
// Two-level encoder: per-row finders, then lowest non-empty row.
module tss_prio_enc #(
  parameter int ROWS   = 16,
  parameter int COLS   = 16,
  localparam int N     = ROWS * COLS,
  localparam int IDX_W = $clog2(N),
  localparam int RW    = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW    = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic [N-1:0]     vec_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [ROWS-1:0]   row_any;
  logic [CW-1:0]     row_pos [ROWS];
  logic [RW-1:0]     row_sel;
  logic [CW-1:0]     col_sel;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    tss_row_enc #(.W(COLS)) u_row (
      .vec_i (vec_i[r*COLS +: COLS]),
      .any_o (row_any[r]),
      .pos_o (row_pos[r])
    );
  end

  always_comb begin
    row_sel = '0;
    for (int r = ROWS - 1; r >= 0; r--) begin
      if (row_any[r]) row_sel = RW'(r);
    end
    col_sel = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (RW'(r) == row_sel) col_sel = row_pos[r];
    end
  end

  assign any_o = |row_any;
  assign idx_o = IDX_W'(row_sel) * IDX_W'(COLS) + IDX_W'(col_sel);
endmodule

// File: rtl/tss_ctrl.sv
module tss_ctrl
  import tss_pkg::*;
#(
  parameter int N     = 256,
  parameter int IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     hit_mask_i,
  input  logic             token_i,
  input  logic             step_i,
  input  logic             enc_any_i,
  input  logic [IDX_W-1:0] enc_idx_i,
  output logic [N-1:0]     rem_o,
  output logic [IDX_W-1:0] chan_idx_o,
  output logic             chan_vld_o,
  output logic             busy_o,
  output logic             token_o
);
  tss_state_e       state_q;
  logic [N-1:0]     rem_q;
  logic [IDX_W-1:0] idx_q;
  logic             vld_q, tok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      idx_q   <= '0;
      vld_q   <= 1'b0;
      tok_q   <= 1'b0;
    end else begin
      tok_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (token_i) begin
            rem_q <= hit_mask_i;
            if (|hit_mask_i) state_q <= ST_SCAN;
            else             tok_q   <= 1'b1;
          end
        end
        ST_SCAN: begin
          if (step_i) begin
            if (enc_any_i) begin
              idx_q <= enc_idx_i;
              vld_q <= 1'b1;
              // drop lowest set bit
              rem_q <= rem_q & (rem_q - {{(N-1){1'b0}}, 1'b1});
            end else begin
              vld_q   <= 1'b0;
              tok_q   <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rem_o      = rem_q;
  assign chan_idx_o = idx_q;
  assign chan_vld_o = vld_q;
  assign busy_o     = (state_q == ST_SCAN);
  assign token_o    = tok_q;
endmodule

// File: rtl/tok_scan_seq.sv
module tok_scan_seq #(
  parameter int ROWS   = 16,
  parameter int COLS   = 16,
  localparam int N     = ROWS * COLS,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     hit_mask_i,
  input  logic             token_i,
  input  logic             step_i,
  output logic [IDX_W-1:0] chan_idx_o,
  output logic             chan_vld_o,
  output logic             busy_o,
  output logic             token_o
);
  logic [N-1:0]     rem;
  logic             enc_any;
  logic [IDX_W-1:0] enc_idx;

  tss_prio_enc #(.ROWS(ROWS), .COLS(COLS)) u_enc (
    .vec_i (rem),
    .any_o (enc_any),
    .idx_o (enc_idx)
  );

  tss_ctrl #(.N(N), .IDX_W(IDX_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hit_mask_i (hit_mask_i),
    .token_i    (token_i),
    .step_i     (step_i),
    .enc_any_i  (enc_any),
    .enc_idx_i  (enc_idx),
    .rem_o      (rem),
    .chan_idx_o (chan_idx_o),
    .chan_vld_o (chan_vld_o),
    .busy_o     (busy_o),
    .token_o    (token_o)
  );
endmodule

// File: rtl/tss_chk.sv
module tss_chk #(
  parameter int N     = 256,
  parameter int IDX_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N-1:0]     hit_mask_i,
  input logic             token_i,
  input logic             step_i,
  input logic [IDX_W-1:0] chan_idx_o,
  input logic             chan_vld_o,
  input logic             busy_o,
  input logic             token_o
);
  logic [N-1:0] cap_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cap_q <= '0;
    else if (!busy_o && token_i) cap_q <= hit_mask_i;
  end

  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && token_i && (|hit_mask_i) |=> busy_o && !chan_vld_o);

  p_ascending_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_vld_o && $past(chan_vld_o) && (chan_idx_o != $past(chan_idx_o))
    |-> chan_idx_o > $past(chan_idx_o));

  // R4, R8: only bits of the snapshot taken at token arrival
  p_hit_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_vld_o |-> cap_q[chan_idx_o]);

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !step_i |=> busy_o && $stable(chan_idx_o) && $stable(chan_vld_o));

  p_tok_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    token_o |=> !token_o);

  p_tok_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    token_o |-> !busy_o && !chan_vld_o);

  p_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && token_i && (hit_mask_i == '0) |=> token_o && !busy_o);

  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !token_i |=> !busy_o && !chan_vld_o && !token_o);
endmodule

bind tok_scan_seq tss_chk #(.N(N), .IDX_W(IDX_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .hit_mask_i (hit_mask_i),
  .token_i    (token_i),
  .step_i     (step_i),
  .chan_idx_o (chan_idx_o),
  .chan_vld_o (chan_vld_o),
  .busy_o     (busy_o),
  .token_o    (token_o)
);

// File: tb/tok_scan_seq_tb.sv
module tok_scan_seq_tb;
  localparam int N = 256;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] mask = '0;
  logic         tok_in = 1'b0;
  logic         step = 1'b0;
  logic [7:0]   idx;
  logic         vld, busy, tok_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference model state
  int  q[$];
  bit  m_busy = 0, m_vld = 0, m_tok = 0;
  int  m_idx = 0;

  always #5 clk = ~clk;

  tok_scan_seq u_dut (
    .clk_i (clk), .rst_ni (rst_n), .hit_mask_i (mask), .token_i (tok_in),
    .step_i (step), .chan_idx_o (idx), .chan_vld_o (vld), .busy_o (busy),
    .token_o (tok_out)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual cycles=%0d expected < 150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic compare(input string tag);
    checks++;
    if (idx !== 8'(m_idx) || vld !== m_vld || busy !== m_busy || tok_out !== m_tok) begin
      errors++;
      $display("FAIL %s: actual idx=%0d vld=%0b busy=%0b tok=%0b expected idx=%0d vld=%0b busy=%0b tok=%0b",
               tag, idx, vld, busy, tok_out, m_idx, m_vld, m_busy, m_tok);
    end
  endtask

  // drive inputs for one edge, predict, then check after the edge
  task automatic cyc(input bit t, input bit s, input logic [N-1:0] mk, input string tag);
    tok_in = t; step = s; mask = mk;
    m_tok = 0;
    if (!m_busy) begin
      if (t) begin
        q.delete();
        for (int i = 0; i < N; i++) if (mk[i]) q.push_back(i);
        if (q.size() == 0) m_tok = 1;
        else               m_busy = 1;
      end
    end else if (s) begin
      if (q.size() != 0) begin
        m_idx = q.pop_front();
        m_vld = 1;
      end else begin
        m_vld = 0; m_tok = 1; m_busy = 0;
      end
    end
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic run_scan(input logic [N-1:0] mk, input string tag);
    int n = 0;
    for (int i = 0; i < N; i++) if (mk[i]) n++;
    cyc(1, 0, mk, tag);
    for (int k = 0; k <= n; k++) cyc(0, 1, mk, tag);
    cyc(0, 0, mk, tag);
  endtask

  initial begin
    logic [N-1:0] m;
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    // R10: steps while idle do nothing
    for (int k = 0; k < 4; k++) cyc(0, 1, '1, "R10");

    // R2/R3/R4/R5: edge channels, idle gaps between steps
    m = '0; m[0] = 1; m[5] = 1; m[15] = 1; m[16] = 1; m[130] = 1; m[255] = 1;
    cyc(1, 0, m, "R2");
    for (int k = 0; k < 7; k++) begin
      cyc(0, 1, m, "R3");
      cyc(0, 0, m, "R5");
      cyc(0, 0, m, "R5");
    end
    cyc(0, 0, m, "R6");

    // R8/R9: mask edits and a new token during a scan
    m = '0; m[3] = 1; m[40] = 1; m[41] = 1; m[200] = 1;
    cyc(1, 0, m, "R2");
    cyc(0, 1, m, "R3");
    cyc(0, 1, '1, "R8");
    cyc(1, 1, ~m, "R9");
    cyc(1, 0, '0, "R9");
    cyc(0, 1, '1, "R8");
    cyc(0, 1, '0, "R6");
    cyc(0, 0, '0, "R6");

    // R7: empty mask passes token at once
    cyc(1, 1, '0, "R7");
    cyc(0, 1, '0, "R7");
    cyc(0, 1, '0, "R7");

    // R6: single last channel, back-to-back tokens
    m = '0; m[255] = 1;
    run_scan(m, "R6");
    m = '0; m[0] = 1;
    run_scan(m, "R6");

    // R3: full mask
    run_scan('1, "R3");

    // R4: random sparse patterns
    for (int r = 0; r < 12; r++) begin
      for (int w = 0; w < 8; w++) m[w*32 +: 32] = $urandom() & $urandom();
      run_scan(m, "R4");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule